// File: doc/BRIEF.md
# Receive-Fill Hysteresis Bus Arbiter

This block shares one system bus between a receive DMA engine and a transmit DMA engine. It watches the fill level of the receive FIFO. When the fill climbs to a high mark, the receive engine takes priority for the bus. That priority stays in force until the fill falls back to a low mark. Both marks are given in eighths of the FIFO depth, and a control bit can turn the whole mechanism off. When no priority is in force, the two engines share the bus in turn.

Once granted, an engine keeps the bus for a tenure of one or more whole bursts. The tenure ends when the engine stops requesting at a burst boundary, or when one more burst would exceed the selected tenure cap. The block also reports the burst length an engine may use, derived from the burst sizes the bus supports. The bus protocol itself lies outside this block.

Top module: `rxthr_bus_arb`

## Requirements
- R1: While `rst` is high at a clock edge, both grants are low after that edge and `burst_len` reads 1.
- R2: A grant is only given to an engine whose request was high at the granting edge. At most one grant is high at any time. With no request, no grant appears.
- R3: When control bit 9 is 1 and `rx_level` >= high mark (control bits 8:6 times DEPTH/8), receive priority is set at the next edge. From then on, an idle arbiter grants receive whenever receive requests. A level of high mark minus one does not set priority.
- R4: Receive priority, once set, holds while the level is above the low mark (control bits 5:3 times DEPTH/8). It clears at the edge after the level is at or below the low mark.
- R5: With control bit 9 at 0, priority is never set, whatever the level.
- R6: Without priority, when both engines request at an idle edge, the grant goes to the engine that was not granted last. After reset, receive counts as not granted last.
- R7: A grant holds until an edge where the owner's done input is high and its request is low. The grant then drops, and one idle cycle follows before the next grant.
- R8: Control bits 15:14 set the tenure cap: 2 gives 32 beats and 3 gives 64 beats. At a done edge the grant is released if the beats used plus one more `burst_len` would exceed the cap, even if the owner still requests.
- R9: Cap values 0 and 1 mean no limit. The grant then holds across any number of done edges while the owner still requests.
- R10: `burst_len` is registered from control bits 2:0, one edge later. Bit 2 set gives 16, else bit 1 gives 8, else bit 0 gives 4, else 1.
- R11: With receive priority set and only transmit requesting, transmit is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 16 | Control word: cap 15:14, enable 9, high 8:6, low 5:3, burst sizes 2:0 |
| rx_level | input | LVL_W | Current receive FIFO fill in entries |
| rx_req | input | 1 | Receive DMA wants the bus |
| tx_req | input | 1 | Transmit DMA wants the bus |
| rx_done | input | 1 | Receive DMA finished a burst |
| tx_done | input | 1 | Transmit DMA finished a burst |
| rx_gnt | output | 1 | Bus granted to receive DMA |
| tx_gnt | output | 1 | Bus granted to transmit DMA |
| burst_len | output | 5 | Beats allowed per burst |

## Verification
The bench builds the block with a FIFO depth of 32. One eighth is then four entries, the default marks sit at fill 24 and fill 8, and a completely full FIFO is within reach of a few level settings. With the 16-beat burst size selected, a 32-beat cap is reached after two bursts and a 64-beat cap after four. Each cap release therefore shows up within a handful of done pulses, next to the unlimited codes 0 and 1.

// File: rtl/rxthr_arb_pkg.sv
package rxthr_arb_pkg;
  localparam int CTRL_W = 16;
  localparam int CAP_W  = 7;
  localparam int CNT_W  = CAP_W + 1;
  localparam int BL_W   = 5;

  // control word field positions (software-visible)
  localparam int F_CAP_HI = 15;
  localparam int F_CAP_LO = 14;
  localparam int F_EN     = 9;
  localparam int F_HI_HI  = 8;
  localparam int F_HI_LO  = 6;
  localparam int F_LO_HI  = 5;
  localparam int F_LO_LO  = 3;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RX   = 2'd1,
    OWN_TX   = 2'd2
  } owner_t;

  function automatic logic [BL_W-1:0] beats_from_sizes(input logic [2:0] sz);
    if (sz[2])      return BL_W'(16);
    else if (sz[1]) return BL_W'(8);
    else if (sz[0]) return BL_W'(4);
    else            return BL_W'(1);
  endfunction
endpackage

// File: rtl/rxthr_ctrl_decode.sv
module rxthr_ctrl_decode
  import rxthr_arb_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              thr_en,
  output logic [LVL_W-1:0]  hi_lvl,
  output logic [LVL_W-1:0]  lo_lvl,
  output logic              cap_lim,
  output logic [CAP_W-1:0]  cap_beats,
  output logic [BL_W-1:0]   burst_len
);
  localparam int EIGHTH = FIFO_DEPTH / 8;

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^ctrl[13:10];

  assign thr_en = ctrl[F_EN];
  assign hi_lvl = LVL_W'(ctrl[F_HI_HI:F_HI_LO]) * LVL_W'(EIGHTH);
  assign lo_lvl = LVL_W'(ctrl[F_LO_HI:F_LO_LO]) * LVL_W'(EIGHTH);

  always_comb begin
    case (ctrl[F_CAP_HI:F_CAP_LO])
      2'd2:    begin cap_lim = 1'b1; cap_beats = CAP_W'(32); end
      2'd3:    begin cap_lim = 1'b1; cap_beats = CAP_W'(64); end
      default: begin cap_lim = 1'b0; cap_beats = '0;         end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) burst_len <= BL_W'(1);
    else     burst_len <= beats_from_sizes(ctrl[2:0]);
  end

  assert_beats_legal_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(burst_len) == 1) && (burst_len != BL_W'(2)));

  assert_beats_follow_R10: assert property (@(posedge clk) disable iff (rst)
    ctrl[2] |=> (burst_len == BL_W'(16)));
endmodule

// File: rtl/rxthr_fill_band.sv
module rxthr_fill_band #(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             thr_en,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] hi_lvl,
  input  logic [LVL_W-1:0] lo_lvl,
  output logic             rx_prio
);
  logic at_high, at_low;
  assign at_high = (level >= hi_lvl);
  assign at_low  = (level <= lo_lvl);

  always_ff @(posedge clk) begin
    if (rst || !thr_en) rx_prio <= 1'b0;
    else if (at_high)   rx_prio <= 1'b1;   // setting wins over clearing
    else if (at_low)    rx_prio <= 1'b0;
  end

  assert_prio_set_R3: assert property (@(posedge clk) disable iff (rst)
    (thr_en && level >= hi_lvl) |=> rx_prio);

  assert_prio_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (thr_en && level <= lo_lvl && level < hi_lvl) |=> !rx_prio);

  assert_prio_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (thr_en && level > lo_lvl && level < hi_lvl) |=> $stable(rx_prio));

  assert_prio_off_R5: assert property (@(posedge clk) disable iff (rst)
    !thr_en |=> !rx_prio);
endmodule

// File: rtl/rxthr_grant_fsm.sv
module rxthr_grant_fsm
  import rxthr_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_prio,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic             rx_done,
  input  logic             tx_done,
  input  logic             cap_lim,
  input  logic [CAP_W-1:0] cap_beats,
  input  logic [BL_W-1:0]  burst_len,
  output logic             rx_gnt,
  output logic             tx_gnt
);
  owner_t           owner_q, pick;
  logic             last_rx_q;
  logic [CNT_W-1:0] used_q, used_next;
  logic             cur_req, cur_done, over_cap;

  // choice made by an idle arbiter
  always_comb begin
    pick = OWN_NONE;
    if (rx_prio) begin
      if (rx_req)      pick = OWN_RX;
      else if (tx_req) pick = OWN_TX;
    end else if (rx_req && tx_req) begin
      pick = last_rx_q ? OWN_TX : OWN_RX;
    end else if (rx_req) begin
      pick = OWN_RX;
    end else if (tx_req) begin
      pick = OWN_TX;
    end
  end

  always_comb begin
    cur_req   = (owner_q == OWN_RX) ? rx_req  : tx_req;
    cur_done  = (owner_q == OWN_RX) ? rx_done : tx_done;
    used_next = used_q + CNT_W'(burst_len);
    over_cap  = cap_lim && ((used_next + CNT_W'(burst_len)) > CNT_W'(cap_beats));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q   <= OWN_NONE;
      last_rx_q <= 1'b0;
      used_q    <= '0;
    end else begin
      case (owner_q)
        OWN_NONE: begin
          owner_q <= pick;
          used_q  <= '0;
          if (pick == OWN_RX) last_rx_q <= 1'b1;
          if (pick == OWN_TX) last_rx_q <= 1'b0;
        end
        default: begin
          if (cur_done) begin
            if (cap_lim) used_q <= used_next;
            if (!cur_req || over_cap) owner_q <= OWN_NONE;
          end
        end
      endcase
    end
  end

  assign rx_gnt = (owner_q == OWN_RX);
  assign tx_gnt = (owner_q == OWN_TX);

  assert_rx_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_gnt) |-> $past(rx_req));

  assert_tx_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_gnt) |-> $past(tx_req));

  assert_hold_rx_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_gnt && !rx_done) |=> rx_gnt);

  assert_hold_tx_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_gnt && !tx_done) |=> tx_gnt);

  assert_used_in_cap_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_lim && (rx_gnt || tx_gnt)) |-> (used_q <= CNT_W'(cap_beats)));

  assert_prio_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (!rx_gnt && !tx_gnt && rx_prio && rx_req) |=> rx_gnt);

  assert_rr_turn_R6: assert property (@(posedge clk) disable iff (rst)
    (!rx_gnt && !tx_gnt && !rx_prio && rx_req && tx_req && last_rx_q) |=> tx_gnt);
endmodule

// File: rtl/rxthr_bus_arb.sv
module rxthr_bus_arb
  import rxthr_arb_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_req,
  input  logic              tx_req,
  input  logic              rx_done,
  input  logic              tx_done,
  output logic              rx_gnt,
  output logic              tx_gnt,
  output logic [BL_W-1:0]   burst_len
);
  logic             thr_en, cap_lim, rx_prio;
  logic [LVL_W-1:0] hi_lvl, lo_lvl;
  logic [CAP_W-1:0] cap_beats;

  rxthr_ctrl_decode #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_dec (
    .clk(clk), .rst(rst), .ctrl(ctrl), .thr_en(thr_en),
    .hi_lvl(hi_lvl), .lo_lvl(lo_lvl), .cap_lim(cap_lim),
    .cap_beats(cap_beats), .burst_len(burst_len)
  );

  rxthr_fill_band #(.LVL_W(LVL_W)) u_band (
    .clk(clk), .rst(rst), .thr_en(thr_en), .level(rx_level),
    .hi_lvl(hi_lvl), .lo_lvl(lo_lvl), .rx_prio(rx_prio)
  );

  rxthr_grant_fsm u_fsm (
    .clk(clk), .rst(rst), .rx_prio(rx_prio), .rx_req(rx_req),
    .tx_req(tx_req), .rx_done(rx_done), .tx_done(tx_done),
    .cap_lim(cap_lim), .cap_beats(cap_beats), .burst_len(burst_len),
    .rx_gnt(rx_gnt), .tx_gnt(tx_gnt)
  );

  assert_one_owner_R2: assert property (@(posedge clk) disable iff (rst)
    !(rx_gnt && tx_gnt));
endmodule

// File: tb/tb_rxthr_bus_arb.sv
module tb_rxthr_bus_arb;
  localparam int DEPTH = 32;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam logic [15:0] C_DEF = 16'h0390; // enable, high 6, low 2

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] ctrl = 16'h0;
  logic [LW-1:0] rx_level = '0;
  logic rx_req = 1'b0, tx_req = 1'b0, rx_done = 1'b0, tx_done = 1'b0;
  logic rx_gnt, tx_gnt;
  logic [4:0] burst_len;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rxthr_bus_arb #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .ctrl(ctrl), .rx_level(rx_level),
    .rx_req(rx_req), .tx_req(tx_req), .rx_done(rx_done), .tx_done(tx_done),
    .rx_gnt(rx_gnt), .tx_gnt(tx_gnt), .burst_len(burst_len)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] c);
    ctrl = c; rx_req = 0; tx_req = 0; rx_done = 0; tx_done = 0; rx_level = '0;
    rst = 1; tick(2); rst = 0;
  endtask

  task automatic release_owner(input bit is_rx);
    if (is_rx) begin rx_done = 1; rx_req = 0; end
    else       begin tx_done = 1; tx_req = 0; end
    tick(); rx_done = 0; tx_done = 0;
  endtask

  task automatic grant_rx_once();
    rx_req = 1; tick(); release_owner(1'b1); tx_req = 0;
  endtask

  task automatic t_reset();
    ctrl = 16'h0007; rx_req = 1; tx_req = 1; rst = 1; tick(2);
    chk("R1 rx_gnt in reset", rx_gnt, 0);
    chk("R1 tx_gnt in reset", tx_gnt, 0);
    chk("R1 burst_len in reset", burst_len, 1);
    rst = 0; tick();
    chk("R10 burst_len sizes 111", burst_len, 16);
    chk("R6 first pick goes rx", rx_gnt, 1);
    rx_req = 0; tx_req = 0;
  endtask

  task automatic t_requests();
    do_reset(16'h0);
    tick(3);
    chk("R2 no request no rx grant", rx_gnt, 0);
    chk("R2 no request no tx grant", tx_gnt, 0);
    tx_req = 1; tick();
    chk("R2 tx only gets tx", tx_gnt, 1);
    chk("R2 rx not granted", rx_gnt, 0);
    release_owner(1'b0);
  endtask

  task automatic t_round_robin();
    do_reset(16'h0);
    rx_req = 1; tx_req = 1; tick();
    chk("R6 both first rx", rx_gnt, 1);
    release_owner(1'b1);
    chk("R7 idle cycle after release", rx_gnt | tx_gnt, 0);
    rx_req = 1; tick();
    chk("R6 alternates to tx", tx_gnt, 1);
    release_owner(1'b0);
    tx_req = 1; tick();
    chk("R6 alternates back to rx", rx_gnt, 1);
    release_owner(1'b1); tx_req = 0;
  endtask

  task automatic t_hysteresis();
    do_reset(C_DEF);
    grant_rx_once();
    rx_level = LW'(24); tick();
    rx_req = 1; tx_req = 1; tick();
    chk("R3 at high mark rx wins", rx_gnt, 1);
    release_owner(1'b1); tx_req = 0;
    rx_level = LW'(10); tick();
    rx_req = 1; tx_req = 1; tick();
    chk("R4 inside band priority kept", rx_gnt, 1);
    release_owner(1'b1); tx_req = 0;
    rx_level = LW'(8); tick();
    rx_req = 1; tx_req = 1; tick();
    chk("R4 at low mark priority cleared", tx_gnt, 1);
    release_owner(1'b0); rx_req = 0;
  endtask

  task automatic t_below_high();
    do_reset(C_DEF);
    grant_rx_once();
    rx_level = LW'(23); tick();
    rx_req = 1; tx_req = 1; tick();
    chk("R3 one below high no priority", tx_gnt, 1);
    release_owner(1'b0); rx_req = 0;
  endtask

  task automatic t_disabled();
    do_reset(16'h0190);
    grant_rx_once();
    rx_level = LW'(32); tick(2);
    rx_req = 1; tx_req = 1; tick();
    chk("R5 disabled ignores full fifo", tx_gnt, 1);
    release_owner(1'b0); rx_req = 0;
  endtask

  task automatic t_prio_tx_only();
    do_reset(C_DEF);
    rx_level = LW'(30); tick();
    tx_req = 1; tick();
    chk("R11 priority but tx alone", tx_gnt, 1);
    release_owner(1'b0);
  endtask

  task automatic t_hold();
    do_reset(16'h0);
    rx_req = 1; tick(); tx_req = 1; tick(5);
    chk("R7 grant held without done", rx_gnt, 1);
    chk("R7 tx waits", tx_gnt, 0);
    release_owner(1'b1);
    chk("R7 dropped on done with req low", rx_gnt | tx_gnt, 0);
    tick();
    chk("R7 tx after idle cycle", tx_gnt, 1);
    release_owner(1'b0);
  endtask

  task automatic t_cap(input logic [15:0] c, input int n_done, input string tag);
    do_reset(c);
    rx_req = 1; tick();
    for (int i = 0; i < n_done - 1; i++) begin
      rx_done = 1; tick(); rx_done = 0;
    end
    chk({tag, " held before cap"}, rx_gnt, 1);
    rx_done = 1; tick(); rx_done = 0;
    chk({tag, " released at cap"}, rx_gnt, 0);
    rx_req = 0; tick();
  endtask

  task automatic t_unlimited(input logic [15:0] c, input string tag);
    do_reset(c);
    rx_req = 1; tick();
    for (int i = 0; i < 6; i++) begin
      rx_done = 1; tick(); rx_done = 0;
    end
    chk({tag, " held with no cap"}, rx_gnt, 1);
    release_owner(1'b1);
    chk({tag, " released when req low"}, rx_gnt, 0);
  endtask

  task automatic t_beats();
    do_reset(16'h0);
    ctrl = 16'h0003; tick();
    chk("R10 sizes 011", burst_len, 8);
    ctrl = 16'h0001; tick();
    chk("R10 sizes 001", burst_len, 4);
    ctrl = 16'h0002; tick();
    chk("R10 sizes 010", burst_len, 8);
    ctrl = 16'h0000; tick();
    chk("R10 sizes 000", burst_len, 1);
  endtask

  initial begin
    tick();
    t_reset();
    t_requests();
    t_round_robin();
    t_hysteresis();
    t_below_high();
    t_disabled();
    t_prio_tx_only();
    t_hold();
    t_cap(16'h8004, 2, "R8 cap 32");
    t_cap(16'hC004, 4, "R8 cap 64");
    t_unlimited(16'h0004, "R9 code 0");
    t_unlimited(16'h4004, "R9 code 1");
    t_beats();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule